// File: doc/BRIEF.md
# Range-Based Memory Protection Checker

This block decides, for every bus-master access, whether the access is allowed by a small bank of programmable address windows. Each window (a descriptor) has an inclusive lower and upper bound kept at 8-byte granularity, a mask saying which masters it applies to, a write-protect flag and a no-execute flag. An access that no applicable window covers is refused. Where several applicable windows cover an address, their restrictions add up, so no descriptor can grant more than another one forbids.

Software programs the bank through a four-register window. One register holds a descriptor index, and the other three (lower bound, upper bound, attributes) read and write the descriptor that index selects. On the access side the block takes the address, the master number, the access kind and the size, and it returns the verdict both combinationally and registered one cycle later.

Top module: `mem_prot_check`

## Requirements
- R1: After reset every descriptor reads back lower bound 0x7FFFF8, upper bound 0 and attributes 0, the index register reads 0, and every access is refused.
- R2: Window offset 0 holds the descriptor index in data bits [2:0]. Offsets 1, 2 and 3 read and write the lower bound, upper bound and attributes of the descriptor that index selects. Attributes hold the master mask in bits [3:0], write-protect in bit 8 and no-execute in bit 9.
- R3: Bits [2:0] of bounds and of access addresses are ignored: bound registers read back with those bits zero, and all eight byte offsets of a block get the same verdict except as R10 requires.
- R4: A descriptor covers an access when lower[22:3] <= addr[22:3] <= upper[22:3], both bounds inclusive, across the full 23-bit address range.
- R5: A descriptor whose lower bound exceeds its upper bound covers nothing.
- R6: A descriptor applies only to masters whose bit is set in its mask.
- R7: An access covered by no applicable descriptor is a violation.
- R8: Access kind codes are 0 read, 1 write, 2 instruction fetch, 3 treated as read. A write under effective write-protect and a fetch under effective no-execute are violations; reads are never refused by the flags.
- R9: Where applicable descriptors overlap, the effective write-protect is the OR of their write-protect bits and the effective no-execute the OR of their no-execute bits.
- R10: A word access (acc_word=1) whose address has bits [2:0] = 7 and whose block equals the upper bound block of any applicable descriptor covering it is a violation.
- R11: A register write changes the verdict only from the clock edge that performs it onward.
- R12: acc_viol_q equals acc_viol of the previous cycle and is 0 while reset is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Register window write strobe |
| cfg_addr | input | 2 | Register window offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data of the offset presented |
| acc_addr | input | 23 | Access byte address |
| acc_master | input | 2 | Master number of the access |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| acc_word | input | 1 | 1 for a two-byte access, 0 for one byte |
| acc_viol | output | 1 | Combinational violation verdict |
| acc_viol_q | output | 1 | Verdict registered one cycle later |

## Verification
Two rules can act on the same access at once: the merge of overlapping descriptors and the upper-boundary fault for a misaligned word. The bench sets up a block that is both an overlap region and the upper bound of one window, then issues word and byte accesses of every kind at every offset of it from each master. A verdict is judged right only when it equals the arithmetic model's, which refuses the boundary word even where the merged rights would allow it, and the same sweep also compares the registered verdict one cycle later.

// File: rtl/mpc_pkg.sv
// Shared definitions of the memory protection checker: access kind
// codes and the layout of the configuration register window.
package mpc_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    localparam logic [1:0] WIN_SEL   = 2'd0;
    localparam logic [1:0] WIN_LOWER = 2'd1;
    localparam logic [1:0] WIN_UPPER = 2'd2;
    localparam logic [1:0] WIN_ATTR  = 2'd3;

    localparam int ATTR_WP_BIT  = 8;
    localparam int ATTR_NEX_BIT = 9;

endpackage

// File: rtl/mpc_desc_bank.sv
// Descriptor storage behind an indexed register window.
// Assumes N_MASTER <= ATTR_WP_BIT and ADDR_W <= DATA_W. Writes land on
// the clock edge; reads are combinational for the offset presented.
module mpc_desc_bank
    import mpc_pkg::*;
#(
    parameter int N_DESC   = 8,
    parameter int N_MASTER = 4,
    parameter int ADDR_W   = 23,
    parameter int GRAN_LSB = 3,
    parameter int DATA_W   = 32
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     cfg_we,
    input  logic [1:0]                               cfg_addr,
    input  logic [DATA_W-1:0]                        cfg_wdata,
    output logic [DATA_W-1:0]                        cfg_rdata,
    output logic [N_DESC-1:0][ADDR_W-GRAN_LSB-1:0]   lo_blk,
    output logic [N_DESC-1:0][ADDR_W-GRAN_LSB-1:0]   hi_blk,
    output logic [N_DESC-1:0][N_MASTER-1:0]          mst_mask,
    output logic [N_DESC-1:0]                        wp,
    output logic [N_DESC-1:0]                        nex
);
    localparam int SEL_W = (N_DESC > 1) ? $clog2(N_DESC) : 1;
    localparam int BLK_W = ADDR_W - GRAN_LSB;

    logic [SEL_W-1:0] sel_q;

    // Update the index register or the selected descriptor field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            for (int i = 0; i < N_DESC; i++) begin
                lo_blk[i]   <= '1;
                hi_blk[i]   <= '0;
                mst_mask[i] <= '0;
                wp[i]       <= 1'b0;
                nex[i]      <= 1'b0;
            end
        end else if (cfg_we) begin
            case (cfg_addr)
                WIN_SEL:   sel_q <= cfg_wdata[SEL_W-1:0];
                WIN_LOWER: lo_blk[sel_q] <= cfg_wdata[ADDR_W-1:GRAN_LSB];
                WIN_UPPER: hi_blk[sel_q] <= cfg_wdata[ADDR_W-1:GRAN_LSB];
                default: begin
                    mst_mask[sel_q] <= cfg_wdata[N_MASTER-1:0];
                    wp[sel_q]       <= cfg_wdata[ATTR_WP_BIT];
                    nex[sel_q]      <= cfg_wdata[ATTR_NEX_BIT];
                end
            endcase
        end
    end

    // Read mux: present the field of the selected descriptor.
    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            WIN_SEL:   cfg_rdata[SEL_W-1:0] = sel_q;
            WIN_LOWER: cfg_rdata[ADDR_W-1:GRAN_LSB] = lo_blk[sel_q];
            WIN_UPPER: cfg_rdata[ADDR_W-1:GRAN_LSB] = hi_blk[sel_q];
            default: begin
                cfg_rdata[N_MASTER-1:0]  = mst_mask[sel_q];
                cfg_rdata[ATTR_WP_BIT]   = wp[sel_q];
                cfg_rdata[ATTR_NEX_BIT]  = nex[sel_q];
            end
        endcase
    end

    AST_LOWER_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == WIN_LOWER) |=>
            lo_blk[$past(sel_q)] == $past(cfg_wdata[ADDR_W-1:GRAN_LSB])); // R2

    AST_UPPER_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == WIN_UPPER) |=>
            hi_blk[$past(sel_q)] == $past(cfg_wdata[ADDR_W-1:GRAN_LSB])); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(lo_blk) && $stable(hi_blk) && $stable(wp)); // R11

    logic [BLK_W-1:0] unused_blk_w;
    assign unused_blk_w = '0;
endmodule

// File: rtl/mpc_range_match.sv
// One descriptor comparator. Decides whether the access block lies in
// the inclusive bound pair for this master and whether a misaligned
// word starts in the last byte of the upper bound block.
// Assumes bounds and the address are already reduced to block numbers.
module mpc_range_match #(
    parameter int N_MASTER = 4,
    parameter int BLK_W    = 20,
    parameter int GRAN_LSB = 3,
    parameter int MID_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BLK_W-1:0]     lo_blk,
    input  logic [BLK_W-1:0]     hi_blk,
    input  logic [N_MASTER-1:0]  mst_mask,
    input  logic [BLK_W-1:0]     acc_blk,
    input  logic [GRAN_LSB-1:0]  acc_off,
    input  logic [MID_W-1:0]     acc_master,
    input  logic                 acc_word,
    output logic                 hit,
    output logic                 edge_fault
);
    logic ordered;

    // Bound comparison gated by bound order and master selection.
    always_comb begin
        ordered    = (lo_blk <= hi_blk);
        hit        = ordered && mst_mask[acc_master]
                     && (lo_blk <= acc_blk) && (acc_blk <= hi_blk);
        edge_fault = hit && acc_word && acc_off[0] && (&acc_off)
                     && (acc_blk == hi_blk);
    end

    AST_REVERSED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_blk > hi_blk) |-> !hit); // R5

    AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        !mst_mask[acc_master] |-> !hit && !edge_fault); // R6

    AST_EDGE_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_word |-> !edge_fault); // R10
endmodule

// File: rtl/mpc_rights_merge.sv
// Accumulates the restrictions of all covering descriptors and forms
// the verdict. Assumes hit, wp, nex and edge vectors share one index.
module mpc_rights_merge
    import mpc_pkg::*;
#(
    parameter int N_DESC = 8
) (
    input  logic [N_DESC-1:0] hit_vec,
    input  logic [N_DESC-1:0] wp_vec,
    input  logic [N_DESC-1:0] nex_vec,
    input  logic [N_DESC-1:0] edge_vec,
    input  acc_kind_e         kind,
    output logic              viol
);
    logic covered, eff_wp, eff_nex;

    // OR the flags of covering descriptors and apply them to the kind.
    always_comb begin
        covered = |hit_vec;
        eff_wp  = |(hit_vec & wp_vec);
        eff_nex = |(hit_vec & nex_vec);
        viol    = !covered
                  || (kind == ACC_WRITE && eff_wp)
                  || (kind == ACC_FETCH && eff_nex)
                  || (|edge_vec);
    end
endmodule

// File: rtl/mem_prot_check.sv
// Top of the memory protection checker. Ties the descriptor bank to one
// comparator per descriptor and to the rights merge, and registers the
// verdict once. Assumes a single clock and synchronous active-low reset.
module mem_prot_check
    import mpc_pkg::*;
#(
    parameter int N_DESC   = 8,
    parameter int N_MASTER = 4,
    parameter int ADDR_W   = 23,
    parameter int GRAN_LSB = 3,
    parameter int DATA_W   = 32
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      cfg_we,
    input  logic [1:0]                                cfg_addr,
    input  logic [DATA_W-1:0]                         cfg_wdata,
    output logic [DATA_W-1:0]                         cfg_rdata,
    input  logic [ADDR_W-1:0]                         acc_addr,
    input  logic [((N_MASTER > 1) ? $clog2(N_MASTER) : 1)-1:0] acc_master,
    input  logic [1:0]                                acc_kind,
    input  logic                                      acc_word,
    output logic                                      acc_viol,
    output logic                                      acc_viol_q
);
    localparam int BLK_W = ADDR_W - GRAN_LSB;
    localparam int MID_W = (N_MASTER > 1) ? $clog2(N_MASTER) : 1;

    logic [N_DESC-1:0][BLK_W-1:0]    lo_blk, hi_blk;
    logic [N_DESC-1:0][N_MASTER-1:0] mst_mask;
    logic [N_DESC-1:0]               wp, nex, hit_vec, edge_vec;
    acc_kind_e                       kind;

    assign kind = acc_kind_e'(acc_kind);

    mpc_desc_bank #(
        .N_DESC(N_DESC), .N_MASTER(N_MASTER), .ADDR_W(ADDR_W),
        .GRAN_LSB(GRAN_LSB), .DATA_W(DATA_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .lo_blk(lo_blk), .hi_blk(hi_blk), .mst_mask(mst_mask),
        .wp(wp), .nex(nex)
    );

    for (genvar d = 0; d < N_DESC; d++) begin : g_cmp
        mpc_range_match #(
            .N_MASTER(N_MASTER), .BLK_W(BLK_W),
            .GRAN_LSB(GRAN_LSB), .MID_W(MID_W)
        ) u_cmp (
            .clk(clk), .rst_n(rst_n),
            .lo_blk(lo_blk[d]), .hi_blk(hi_blk[d]), .mst_mask(mst_mask[d]),
            .acc_blk(acc_addr[ADDR_W-1:GRAN_LSB]),
            .acc_off(acc_addr[GRAN_LSB-1:0]),
            .acc_master(acc_master), .acc_word(acc_word),
            .hit(hit_vec[d]), .edge_fault(edge_vec[d])
        );
    end

    mpc_rights_merge #(.N_DESC(N_DESC)) u_merge (
        .hit_vec(hit_vec), .wp_vec(wp), .nex_vec(nex),
        .edge_vec(edge_vec), .kind(kind), .viol(acc_viol)
    );

    // Registered copy of the verdict for timing-critical consumers.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_viol_q <= 1'b0;
        else        acc_viol_q <= acc_viol;
    end

    AST_UNCOVERED_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec == '0) |-> acc_viol); // R7

    AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_WRITE && (hit_vec & wp) != '0) |-> acc_viol); // R8

    AST_FETCH_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_FETCH && (hit_vec & nex) != '0) |-> acc_viol); // R8

    AST_EDGE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_vec != '0) |-> acc_viol); // R10

    AST_READ_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != ACC_WRITE && kind != ACC_FETCH && hit_vec != '0
         && edge_vec == '0) |-> !acc_viol); // R8

    AST_REG_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> acc_viol_q == $past(acc_viol)); // R12
endmodule

// File: tb/test_mem_prot_check.sv
`timescale 1ns/1ps
module test_mem_prot_check;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [22:0] acc_addr = '0;
    logic [1:0]  acc_master = '0;
    logic [1:0]  acc_kind = '0;
    logic        acc_word = 1'b0;
    logic        acc_viol, acc_viol_q;

    int n_chk = 0;
    int n_err = 0;

    // Bench model of the descriptor bank, in block units.
    int m_sel = 0;
    int m_lo[8];
    int m_hi[8];
    int m_mask[8];
    int m_wp[8];
    int m_nex[8];

    always #2.5 clk = ~clk;

    mem_prot_check i_mem_prot_check (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_addr(acc_addr),
        .acc_master(acc_master), .acc_kind(acc_kind), .acc_word(acc_word),
        .acc_viol(acc_viol), .acc_viol_q(acc_viol_q)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h (addr=%0h m=%0d k=%0d w=%0d)",
                     req, act, exp, acc_addr, acc_master, acc_kind, acc_word);
        end
    endtask

    task automatic model_reset();
        m_sel = 0;
        for (int i = 0; i < 8; i++) begin
            m_lo[i] = 32'hFFFFF; m_hi[i] = 0; m_mask[i] = 0;
            m_wp[i] = 0; m_nex[i] = 0;
        end
    endtask

    // Expected verdict from the requirements, with the deciding rule.
    function automatic logic exp_viol(input int a, input int m, input int k,
                                      input logic w, output string why);
        int  blk = a >> 3;
        int  off = a & 7;
        int  cov = 0;
        logic any_wp = 0, any_nex = 0, edge_hit = 0, masked_out = 0;
        for (int i = 0; i < 8; i++) begin
            if (m_lo[i] <= m_hi[i] && m_lo[i] <= blk && blk <= m_hi[i]) begin
                if (((m_mask[i] >> m) & 1) == 1) begin
                    cov++;
                    any_wp  |= (m_wp[i] != 0);
                    any_nex |= (m_nex[i] != 0);
                    if (w && off == 7 && blk == m_hi[i]) edge_hit = 1;
                end else begin
                    masked_out = 1;
                end
            end
        end
        if (edge_hit)              begin why = "R10"; return 1; end
        if (cov == 0)              begin why = masked_out ? "R6" : "R7"; return 1; end
        if (k == 1 && any_wp)      begin why = (cov > 1) ? "R9" : "R8"; return 1; end
        if (k == 2 && any_nex)     begin why = (cov > 1) ? "R9" : "R8"; return 1; end
        why = (cov > 1) ? "R9" : "R4";
        return 0;
    endfunction

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        case (a)
            2'd0: m_sel = int'(d[2:0]);
            2'd1: m_lo[m_sel] = int'(d[22:3]);
            2'd2: m_hi[m_sel] = int'(d[22:3]);
            default: begin
                m_mask[m_sel] = int'(d[3:0]);
                m_wp[m_sel] = int'(d[8]);
                m_nex[m_sel] = int'(d[9]);
            end
        endcase
    endtask

    task automatic set_desc(input int idx, input int lo, input int hi,
                            input int mask, input int wpv, input int nexv);
        cfg_write(2'd0, 32'(idx));
        cfg_write(2'd1, 32'(lo << 3) | 32'h5);
        cfg_write(2'd2, 32'(hi << 3) | 32'h2);
        cfg_write(2'd3, 32'(mask) | 32'(wpv << 8) | 32'(nexv << 9));
    endtask

    task automatic read_check(input logic [1:0] a, input logic [31:0] exp,
                              input string req);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(req, cfg_rdata, exp);
    endtask

    // Drive one access, check the live verdict, then the registered one.
    task automatic apply(input int a, input int m, input int k, input logic w,
                         input string tag);
        string why;
        logic  e;
        e = exp_viol(a, m, k, w, why);
        @(negedge clk);
        acc_addr = 23'(a); acc_master = 2'(m); acc_kind = 2'(k); acc_word = w;
        #1;
        check((tag == "") ? why : tag, 32'(acc_viol), 32'(e));
        @(posedge clk); #1;
        check("R12", 32'(acc_viol_q), 32'(e));
    endtask

    task automatic sweep(input int blocks);
        for (int b = 0; b < blocks; b++)
            for (int o = 0; o < 8; o++)
                for (int m = 0; m < 4; m++)
                    for (int k = 0; k < 3; k++)
                        for (int w = 0; w < 2; w++)
                            apply((b << 3) | o, m, k, w[0], "");
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (4) @(posedge clk);
        #1;
        check("R12", 32'(acc_viol_q), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents of every descriptor
        read_check(2'd0, 32'd0, "R1");
        for (int d = 0; d < 8; d++) begin
            cfg_write(2'd0, 32'(d));
            read_check(2'd1, 32'h7FFFF8, "R1");
            read_check(2'd2, 32'h0, "R1");
            read_check(2'd3, 32'h0, "R1");
        end
        for (int m = 0; m < 4; m++) apply(32'h123 + m, m, 0, 1'b0, "R1");
        sweep(4);

        // Programmed bank: overlap, masks, reversed bounds, single block
        set_desc(0, 2, 5, 4'b0011, 1, 0);
        set_desc(1, 4, 9, 4'b0110, 0, 1);
        set_desc(2, 13, 12, 4'b1111, 0, 0);
        set_desc(3, 11, 11, 4'b1000, 0, 0);
        set_desc(7, 14, 14, 4'b1111, 1, 1);
        set_desc(6, 32'hFFFFF, 32'hFFFFF, 4'b0101, 0, 1);

        // R2 / R3: readback through the selected window, low bits dropped
        for (int d = 0; d < 8; d++) begin
            cfg_write(2'd0, 32'(d));
            read_check(2'd0, 32'(d), "R2");
            read_check(2'd1, 32'(m_lo[d] << 3) & 32'h7FFFF8, "R3");
            read_check(2'd2, 32'(m_hi[d] << 3), "R2");
            read_check(2'd3, 32'(m_mask[d]) | 32'(m_wp[d] << 8)
                             | 32'(m_nex[d] << 9), "R2");
        end

        // R3: every offset of a block gets the same byte verdict
        for (int o = 0; o < 8; o++) apply((3 << 3) | o, 0, 1, 1'b0, "R3");
        // R5: reversed-bound descriptor covers neither of its blocks
        for (int k = 0; k < 3; k++) begin
            apply(12 << 3, 0, k, 1'b0, "R5");
            apply((13 << 3) | 4, 3, k, 1'b0, "R5");
        end
        // R4: top of the address space, inclusive bounds
        apply(32'h7FFFF8, 0, 1, 1'b0, "R4");
        apply(32'h7FFFFF, 2, 0, 1'b0, "R4");
        apply(32'h7FFFF7, 0, 0, 1'b0, "R4");
        apply(32'h7FFFFF, 0, 2, 1'b0, "R8");
        apply(32'h7FFFFF, 0, 0, 1'b1, "R10");
        apply(32'h7FFFFE, 0, 0, 1'b1, "R4");
        // R9 with R10 in the same block: block 5 is overlap and upper bound
        apply((5 << 3) | 7, 1, 0, 1'b1, "R10");
        apply((5 << 3) | 7, 1, 0, 1'b0, "R9");
        apply((5 << 3) | 6, 1, 1, 1'b1, "R9");
        apply((4 << 3) | 1, 1, 2, 1'b0, "R9");
        apply((4 << 3) | 1, 1, 0, 1'b1, "R9");
        // R8: reserved kind code behaves as a read
        apply(14 << 3, 2, 3, 1'b0, "R8");

        sweep(16);

        // R11: the enabling write takes effect at its own edge only
        cfg_write(2'd0, 32'd5);
        cfg_write(2'd3, 32'h00F);
        @(negedge clk);
        acc_addr = 23'h000002; acc_master = 2'd0; acc_kind = 2'd0; acc_word = 1'b0;
        cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = 32'h0;
        #1;
        check("R11", 32'(acc_viol), 32'd1);
        @(posedge clk); #1;
        cfg_we = 1'b0;
        m_lo[5] = 0;
        check("R11", 32'(acc_viol), 32'd0);
        apply(32'h000002, 0, 1, 1'b0, "R11");

        finish_run();
    end
endmodule